// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This block gathers single-cycle event pulses from a card host controller's command engine and data path into a sticky status register. It also watches an asynchronous card-detect input and raises its own card-change event. Software reads the status word, enables interrupt sources through a mask register, and acknowledges events by writing ones to a separate clear register.

The interrupt output is the OR of every pending event whose mask bit is set. Two status bits are not events but live levels: one shows card absence and one shows write protection. They follow their inputs and cannot be cleared. The card-detect input passes through a two-flop synchroniser and then a glitch filter before its level is used. Event bit positions: 0 response CRC error, 1 data CRC error, 2 response timeout, 3 data timeout, 4 response CRC good, 5 data CRC good, 6 command sent, 7 data end, 8 FIFO underrun, 9 FIFO overrun, 10 card change. The status, mask and clear registers all use this layout.

Top module: `sd_evt_status`

## Requirements
- R1: After reset the status event bits [10:0] read 0, the mask reads 0 and irq_o is low.
- R2: A one-cycle pulse on evt_i[n] (n in 0..9) sets status bit n on the next clock edge. The bit stays set until it is cleared.
- R3: A write to the clear register (address 2) clears each status event bit whose written bit is 1 and leaves every bit written 0 unchanged.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit is set afterwards.
- R5: irq_o is high exactly when some bit of (status AND mask) over [10:0] is 1. A mask of zero holds irq_o low.
- R6: The mask register (address 1) stores wdata_i[10:0] and reads back the same value.
- R7: A change of card_det_i that holds for at least 2 clocks after the two-flop synchroniser updates status bit 11 to the new level (1 means no card) and sets event bit 10.
- R8: A card_det_i pulse shorter than 2 clocks after synchronisation changes neither status bit 11 nor event bit 10.
- R9: Status bit 12 follows wp_i through a two-flop synchroniser. Clear-register writes to bits 11 and 12 have no effect on either bit.
- R10: The status register reads at address 0. Writes to address 0 change nothing. The clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | 10 | Event pulses for bits 0..9 |
| card_det_i | input | 1 | Asynchronous card-detect level, 1 = no card |
| wp_i | input | 1 | Asynchronous write-protect level |
| irq_o | output | 1 | Interrupt, OR of masked pending events |

## Verification
A vector table sends event pulses, clears and masks together in the same cycle and in varied patterns: single bits, the alternating 0x155/0x2AA patterns and all-ones. This separates sticky setting from clearing, shows that the event wins when it collides with a clear, and shows that a pending bit only reaches irq_o when its mask bit is set. Directed tests then apply a long card-detect change and a one-cycle glitch. The long change must raise event bit 10 and the glitch must not, which separates the filter from the plain edge path. Further directed tests write the level bits through the clear register and write to the status address, and both must leave the readout unchanged.

// File: rtl/sd_evt_pkg.sv
package sd_evt_pkg;
  localparam int EVT_W   = 11;
  localparam int EXT_W   = 10;
  localparam int CHG_BIT = 10;
  localparam int CD_BIT  = 11;
  localparam int WP_BIT  = 12;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_CLR  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sd_sync2.sv
module sd_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sd_cd_filter.sv
module sd_cd_filter #(
  parameter int FILT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic chg_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          sync;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  sd_sync2 u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_i), .q_o(sync));

  // level accepted only after FILT_CYC consecutive differing samples
  assign chg_o = (sync != lvl_q) && (cnt_q == CW'(FILT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (sync == lvl_q) begin
      cnt_q <= '0;
    end else if (chg_o) begin
      lvl_q <= sync;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  assert_chg_flips_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> (lvl_q != $past(lvl_q)));
  assert_lvl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_o |=> $stable(lvl_q));
  assert_chg_needs_diff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (sync != lvl_q));
endmodule

// File: rtl/sd_evt_bank.sv
module sd_evt_bank #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q[i] <= 1'b0;
      else if (set_i[i]) st_q[i] <= 1'b1;   // set wins over clear
      else if (clr_i[i]) st_q[i] <= 1'b0;
    end

    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);
    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_q[i]);
    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !st_q[i]);
  end

  assign st_o = st_q;
endmodule

// File: rtl/sd_evt_status.sv
module sd_evt_status
  import sd_evt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FILT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EXT_W-1:0]  evt_i,
  input  logic              card_det_i,
  input  logic              wp_i,
  output logic              irq_o
);
  localparam int PAD = DATA_W - WP_BIT - 1;

  logic [EVT_W-1:0] mask_q, st, set_v, clr_v;
  logic             cd_lvl, cd_chg, wp_lvl;
  logic             wr_stat, wr_mask, wr_clr;

  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_clr  = wr_en_i && (addr_i == A_CLR);

  sd_cd_filter #(.FILT_CYC(FILT_CYC)) u_cd (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(card_det_i),
    .lvl_o(cd_lvl), .chg_o(cd_chg)
  );

  sd_sync2 u_wp (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(wp_i), .q_o(wp_lvl));

  assign set_v = {cd_chg, evt_i};
  assign clr_v = wr_clr ? wdata_i[EVT_W-1:0] : '0;

  sd_evt_bank #(.W(EVT_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v), .st_o(st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[EVT_W-1:0];
  end

  assign irq_o = |(st & mask_q);

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = {{PAD{1'b0}}, wp_lvl, cd_lvl, st};
      A_MASK:  rdata_o = {{(DATA_W-EVT_W){1'b0}}, mask_q};
      default: rdata_o = '0;
    endcase
  end

  assert_mask_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  assert_stat_wr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && set_v == '0) |=> $stable(st));
  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/sd_evt_status_bench.sv
module sd_evt_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        card_det = 1'b0;
  logic        wp = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sd_evt_status u_sd_evt_status (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .card_det_i(card_det),
    .wp_i(wp), .irq_o(irq)
  );

  // {evt[9:0], clr[10:0], mask[10:0], exp_status[10:0], exp_irq}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {10'h001, 11'h000, 11'h001, 11'h001, 1'b1},
    {10'h002, 11'h001, 11'h001, 11'h002, 1'b0},
    {10'h004, 11'h004, 11'h006, 11'h006, 1'b1},
    {10'h000, 11'h000, 11'h000, 11'h006, 1'b0},
    {10'h3F0, 11'h006, 11'h200, 11'h3F0, 1'b1},
    {10'h000, 11'h0F0, 11'h200, 11'h300, 1'b1},
    {10'h000, 11'h7FF, 11'h7FF, 11'h000, 1'b0},
    {10'h155, 11'h000, 11'h2AA, 11'h155, 1'b0},
    {10'h2AA, 11'h155, 11'h2AA, 11'h2AA, 1'b1},
    {10'h000, 11'h2AA, 11'h7FF, 11'h000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(2'd0, r); chk("R1 status", r, 32'h0);
    rd(2'd1, r); chk("R1 mask", r, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      evt = VEC[v][43:34];
      wr_en = 1'b1; addr = 2'd2; wdata = {21'b0, VEC[v][33:23]};
      @(negedge clk);
      evt = '0;
      addr = 2'd1; wdata = {21'b0, VEC[v][22:12]};
      @(negedge clk);
      wr_en = 1'b0;
      rd(2'd0, r); chk("R2 R3 R4 status", r, {21'b0, VEC[v][11:1]});
      rd(2'd1, r); chk("R6 mask readback", r, {21'b0, VEC[v][22:12]});
      chk("R5 irq", {31'b0, irq}, {31'b0, VEC[v][0]});
    end

    // R10 writes to status ignored, clear reads 0
    @(negedge clk); evt = 10'h081;
    @(negedge clk); evt = '0;
    wr(2'd0, 32'h0000_07FF);
    rd(2'd0, r); chk("R10 status write ignored", r, 32'h081);
    rd(2'd2, r); chk("R10 clear reads zero", r, 32'h0);
    wr(2'd1, 32'h0);
    chk("R5 zero mask no irq", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h7FF);

    // R7 card removal
    wr(2'd1, 32'h400);
    card_det = 1'b1;
    idle(6);
    rd(2'd0, r); chk("R7 removal sets chg and level", r, 32'h0C00);
    chk("R7 irq on card change", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h400);
    rd(2'd0, r); chk("R7 chg cleared level kept", r, 32'h0800);

    // R8 one-cycle glitch low
    @(negedge clk); card_det = 1'b0;
    @(negedge clk); card_det = 1'b1;
    idle(6);
    rd(2'd0, r); chk("R8 glitch ignored", r, 32'h0800);
    chk("R8 no irq", {31'b0, irq}, 32'h0);

    // R7 card insertion
    card_det = 1'b0;
    idle(6);
    rd(2'd0, r); chk("R7 insertion", r, 32'h0400);
    wr(2'd2, 32'h400);

    // R9 write protect
    wp = 1'b1;
    idle(3);
    rd(2'd0, r); chk("R9 wp level", r, 32'h1000);
    card_det = 1'b1;
    idle(6);
    wr(2'd2, 32'h1800);
    rd(2'd0, r); chk("R9 levels not clearable", r, 32'h1C00);
    wp = 1'b0;
    idle(3);
    rd(2'd0, r); chk("R9 wp released", r, 32'h0C00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule